// File: doc/BRIEF.md
# Memory Bit-Clear Read-Modify-Write Sequencer

This block clears one bit of a byte held in memory and reports the state that bit had beforehand. A request arrives as a single-cycle start pulse together with a base value and the operands for one of two addressing forms. In the immediate form, the byte address is the base plus a 16-bit displacement extended by its sign, and a 3-bit immediate names the bit. In the register form, the base is the byte address as it stands, and the low three bits of a second register value name the bit.

Once a request is accepted, the sequencer makes a fixed three-cycle pass. The accepting cycle captures the address and the bit number. The next cycle issues a byte read. The third cycle writes the byte back with the chosen bit forced to zero and the other seven bits unchanged. In that same write cycle it drives the new zero flag (set when the old bit was 0) with an update strobe and a done pulse. The bus lock is held across the read and the write so that no other master can reach the byte in between. The block changes nothing other than that byte and the zero flag.

Top module: `bitclr_rmw`

## Requirements
- R1: When `form_reg` is 0 at an accepted start, the byte address is `base_val` plus `disp16` sign-extended to 32 bits (modulo 2^32), and the bit number is `bit_imm`.
- R2: When `form_reg` is 1 at an accepted start, the byte address is `base_val` and the bit number is `bit_reg[2:0]`; `disp16`, `bit_imm` and `bit_reg[31:3]` have no effect.
- R3: In the write cycle, `z_flag` is 1 exactly when the addressed bit (bit n of `mem_rdata`, where bit 0 is the LSB) was 0 before the write.
- R4: `mem_wdata` equals the byte that was read with bit n cleared and bits other than n unchanged; the write happens even when bit n was already 0.
- R5: A start accepted at clock edge k gives `mem_rd` high for the cycle after edge k and `mem_wr`, `done` and `z_upd` high for the cycle after edge k+1, each for one cycle only; the unit is idle again after edge k+2.
- R6: `mem_lock` is high in the read cycle and the write cycle and low while the unit is idle.
- R7: A start raised while a pass is running (in the read or the write cycle) is ignored: the running pass keeps its captured address and bit, and no read follows the write.
- R8: While reset is held, and after it is released with no start, `mem_rd`, `mem_wr`, `mem_lock`, `done`, `z_upd` and `z_flag` are 0.
- R9: The read and the write of one pass use the same address, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request; accepted only when the unit is idle |
| form_reg | input | 1 | 0 = displacement plus immediate bit, 1 = register bit with no displacement |
| base_val | input | 32 | Base address value |
| disp16 | input | 16 | Signed displacement for the immediate form |
| bit_imm | input | 3 | Bit number for the immediate form |
| bit_reg | input | 32 | Register value whose low 3 bits give the bit number in the register form |
| mem_rd | output | 1 | Byte read strobe; data returns on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Byte write strobe |
| mem_lock | output | 1 | Bus lock held across the read and the write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Byte written back |
| mem_rdata | input | 8 | Byte read, valid in the cycle after `mem_rd` |
| z_flag | output | 1 | New zero flag value, valid with `z_upd` |
| z_upd | output | 1 | Zero flag update strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the end of one pass, with its write, flag strobe and done pulse, and a start request for a new pass. Start can also arrive during the read cycle. The bench provokes both cases by holding start high, with different operands, through the read and write cycles of a running pass. It judges the result in two ways. The scoreboard must see the running pass write to the address and with the data of the original operands. The cycle after the write must show no read and no lock, which proves that the stray requests were dropped and did not start a new pass.

// File: rtl/bitclr_pkg.sv
package bitclr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  typedef enum logic {
    FORM_IMM = 1'b0,
    FORM_REG = 1'b1
  } addr_form_e;

endpackage

// File: rtl/bitclr_rst_sync.sv
module bitclr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // Asserts at once, releases after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bitclr_operand.sv
module bitclr_operand
  import bitclr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  addr_form_e        form,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [BIT_W-1:0]  bit_imm,
  input  logic [ADDR_W-1:0] bit_reg,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BIT_W-1:0]  bitsel_q
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] addr_d;
  logic [BIT_W-1:0]  bitsel_d;

  always_comb begin
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    if (form == FORM_REG) begin
      addr_d   = base_val;
      bitsel_d = bit_reg[BIT_W-1:0];
    end else begin
      addr_d   = base_val + disp_ext;
      bitsel_d = bit_imm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      bitsel_q <= '0;
    end else if (capture_en) begin
      addr_q   <= addr_d;
      bitsel_q <= bitsel_d;
    end
  end

  // Captured operands only move on an accepted request.
  assert_operands_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_en |=> $stable(addr_q) && $stable(bitsel_q));

endmodule

// File: rtl/bitclr_seq.sv
module bitclr_seq
  import bitclr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic capture_en,
  output logic rd_en,
  output logic wr_en,
  output logic lock,
  output logic done
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    capture_en = (state_q == ST_IDLE) && start;
    rd_en      = (state_q == ST_READ);
    wr_en      = (state_q == ST_WRITE);
    lock       = rd_en || wr_en;
    done       = wr_en;
  end

  assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en);

  assert_write_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en));

  assert_busy_start_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) && start |=> !rd_en);

  assert_single_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en, wr_en}));

endmodule

// File: rtl/bitclr_merge.sv
module bitclr_merge #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [BIT_W-1:0]  bitsel,
  output logic [DATA_W-1:0] wdata,
  output logic              z_new
);

  // One lane per data bit: the selected lane is forced low.
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign wdata[g] = rdata[g] & (bitsel != BIT_W'(g));
  end

  assign z_new = ~rdata[bitsel];

endmodule

// File: rtl/bitclr_rmw.sv
module bitclr_rmw
  import bitclr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              form_reg,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp16,
  input  logic [2:0]        bit_imm,
  input  logic [ADDR_W-1:0] bit_reg,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              z_flag,
  output logic              z_upd,
  output logic              done
);

  localparam int BIT_W = $clog2(DATA_W);

  logic             rst_core_n;
  logic             capture_en;
  logic             rd_en, wr_en, lock, seq_done;
  logic [BIT_W-1:0] bitsel_q;
  logic             z_new;

  bitclr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_core_n)
  );

  bitclr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .capture_en (capture_en),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .lock       (lock),
    .done       (seq_done)
  );

  bitclr_operand #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .BIT_W  (BIT_W)
  ) u_operand (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .capture_en (capture_en),
    .form       (addr_form_e'(form_reg)),
    .base_val   (base_val),
    .disp       (disp16),
    .bit_imm    (bit_imm[BIT_W-1:0]),
    .bit_reg    (bit_reg),
    .addr_q     (mem_addr),
    .bitsel_q   (bitsel_q)
  );

  bitclr_merge #(
    .DATA_W (DATA_W),
    .BIT_W  (BIT_W)
  ) u_merge (
    .rdata  (mem_rdata),
    .bitsel (bitsel_q),
    .wdata  (mem_wdata),
    .z_new  (z_new)
  );

  assign mem_rd   = rd_en;
  assign mem_wr   = wr_en;
  assign mem_lock = lock;
  assign done     = seq_done;
  assign z_upd    = seq_done;
  assign z_flag   = seq_done & z_new;

  assert_lock_covers_access_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mem_rd || mem_wr) |-> mem_lock);

  assert_same_address_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_wr |-> $stable(mem_addr));

  assert_done_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |-> (z_upd && mem_wr));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |=> !done);

  // Exactly one set bit disappears unless it was already clear.
  assert_one_bit_dropped_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_wr |-> ($countones(mem_wdata) + (z_flag ? 0 : 1)) == $countones(mem_rdata));

  assert_flag_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !mem_wr |-> !z_flag && !z_upd);

endmodule

// File: tb/bitclr_rmw_bench.sv
module bitclr_rmw_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] addr;
    logic [7:0]  wdata;
    logic        z;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        form_reg;
  logic [31:0] base_val;
  logic [15:0] disp16;
  logic [2:0]  bit_imm;
  logic [31:0] bit_reg;
  logic        mem_rd, mem_wr, mem_lock;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        z_flag, z_upd, done;

  logic [7:0]  mem [64];
  logic        pl_en;
  logic [5:0]  pl_idx;
  logic [7:0]  pl_val;

  exp_t        sb_q[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitclr_rmw u_bitclr_rmw (
    .clk (clk), .rst_n (rst_n), .start (start), .form_reg (form_reg),
    .base_val (base_val), .disp16 (disp16), .bit_imm (bit_imm), .bit_reg (bit_reg),
    .mem_rd (mem_rd), .mem_wr (mem_wr), .mem_lock (mem_lock), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .z_flag (z_flag), .z_upd (z_upd), .done (done)
  );

  // Byte memory, read data one cycle after the strobe.
  always @(posedge clk) begin
    if (pl_en)  mem[pl_idx] <= pl_val;
    if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      pl_en = 1'b1; pl_idx = 6'(i); pl_val = 8'((i * 37 + 5) ^ 8'hA5);
    end
    @(negedge clk);
    pl_en = 1'b0;
    @(negedge clk);
  endtask

  // Driver: compute the expected result, push it, run the pass with cycle checks.
  task automatic run_op(input bit freg, input logic [31:0] base, input logic [15:0] dsp,
                        input logic [2:0] bimm, input logic [31:0] breg, input bit poke);
    exp_t        e;
    logic [2:0]  n;
    logic [7:0]  old;
    e.addr = freg ? base : base + {{16{dsp[15]}}, dsp};
    n      = freg ? breg[2:0] : bimm;
    old    = mem[e.addr[5:0]];
    e.wdata = old & ~(8'h01 << n);
    e.z     = ~old[n];
    sb_q.push_back(e);

    @(negedge clk);
    start = 1'b1; form_reg = freg; base_val = base; disp16 = dsp;
    bit_imm = bimm; bit_reg = breg;
    @(negedge clk);  // read cycle
    check(mem_rd && !mem_wr, "R5 read cycle", {30'd0, mem_rd, mem_wr}, 32'h2);
    check(mem_lock, "R6 lock in read", {31'd0, mem_lock}, 32'd1);
    check(mem_addr == e.addr, freg ? "R2 address" : "R1 address", mem_addr, e.addr);
    if (poke) begin
      start = 1'b1; form_reg = ~freg; base_val = base ^ 32'h0000_0015;
      disp16 = 16'h0003; bit_imm = ~bimm; bit_reg = ~breg;
    end else begin
      start = 1'b0;
    end
    @(negedge clk);  // write cycle
    check(mem_wr && !mem_rd && done && z_upd, "R5 write cycle",
          {28'd0, mem_wr, mem_rd, done, z_upd}, 32'hB);
    check(mem_lock, "R6 lock in write", {31'd0, mem_lock}, 32'd1);
    @(negedge clk);  // back to idle
    start = 1'b0;
    check(!mem_rd && !mem_wr && !done && !z_upd,
          poke ? "R7 busy start ignored" : "R5 single pass",
          {28'd0, mem_rd, mem_wr, done, z_upd}, 32'h0);
    check(!mem_lock, "R6 lock released", {31'd0, mem_lock}, 32'd0);
  endtask

  // Monitor: pop and compare on every write.
  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R5 unexpected write", mem_addr, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(mem_addr == e.addr, "R9 write address", mem_addr, e.addr);
        check(mem_wdata == e.wdata, "R4 written byte", {24'd0, mem_wdata}, {24'd0, e.wdata});
        check(z_flag == e.z, "R3 zero flag", {31'd0, z_flag}, {31'd0, e.z});
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; form_reg = 1'b0; base_val = '0; disp16 = '0;
    bit_imm = '0; bit_reg = '0; pl_en = 1'b0; pl_idx = '0; pl_val = '0;
    repeat (3) @(negedge clk);
    check(!mem_rd && !mem_wr && !mem_lock && !done && !z_upd && !z_flag, "R8 in reset",
          {26'd0, mem_rd, mem_wr, mem_lock, done, z_upd, z_flag}, 32'h0);
    rst_n = 1'b1;
    preload();
    check(!mem_rd && !mem_wr && !mem_lock && !done && !z_upd && !z_flag, "R8 after reset",
          {26'd0, mem_rd, mem_wr, mem_lock, done, z_upd, z_flag}, 32'h0);

    // R1: positive and negative displacements, wrap past zero.
    run_op(1'b0, 32'h0000_0010, 16'h0005, 3'd3, 32'hFFFF_FFFF, 1'b0);
    run_op(1'b0, 32'h0000_0120, 16'hFFF0, 3'd7, 32'h0, 1'b0);
    run_op(1'b0, 32'h0000_0002, 16'hFFFC, 3'd0, 32'h0, 1'b0);
    // R2: register form ignores disp, bit_imm and the upper register bits.
    run_op(1'b1, 32'h0000_0008, 16'h1234, 3'd6, 32'hFFFF_FFF9, 1'b0);
    // R4/R3: same bit twice, second pass writes an unchanged byte with Z=1.
    run_op(1'b1, 32'h0000_0021, 16'h0, 3'd0, 32'h0000_0004, 1'b0);
    run_op(1'b1, 32'h0000_0021, 16'h0, 3'd0, 32'h0000_0004, 1'b0);
    // Every bit of one byte in turn, leaving it zero.
    for (int b = 0; b < 8; b++)
      run_op(1'b0, 32'h0000_0030, 16'h0000, 3'(b), 32'h0, 1'b0);
    // R7: start held through the read and write of a running pass.
    run_op(1'b0, 32'h0000_0004, 16'h0001, 3'd2, 32'h0, 1'b1);
    run_op(1'b1, 32'h0000_003C, 16'h7FFF, 3'd1, 32'h0000_0013, 1'b1);
    // Pass right after a poked one still uses its own operands.
    run_op(1'b0, 32'h0000_0040, 16'hFFFA, 3'd5, 32'h0, 1'b0);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R5 all passes completed", sb_q.size(), 32'd0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R5 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule